// File: doc/BRIEF.md
# Paged NIC Control Register File

This block is the host-facing register bank of a small Ethernet controller. A host reaches it over an 8-bit bus with sixteen byte addresses. Offset 0 is always the command register. Its two top bits choose which of four register pages the other fifteen offsets refer to. The bank holds these registers:

- the receive ring start, stop, boundary and current pages;
- the transmit page and byte count;
- the remote DMA address and count;
- the data configuration;
- the interrupt status and mask;
- the six station address bytes and the eight multicast filter bytes.

The receive, transmit and DMA engines use the bank in two ways. They report completion through single-cycle event pulses, which set status bits. They read the configuration values from dedicated outputs. A level interrupt goes high whenever an unmasked status bit is set.

Command writes have side effects:
- A start command clears the reset-done flag.
- A start command that asks for a remote transfer while the remote count is zero completes that transfer at once.
- A start command with the transmit bit issues a transmit request to the media side.

The transmit request leaves the block on a valid/ready pair. Once `tx_valid` rises, it stays high with `tx_page` and `tx_count` unchanged until a cycle where `tx_ready` is also high. That cycle ends the transfer. A new transmit command that arrives while a request is outstanding is dropped. The transmitter later reports completion with a `tx_done` pulse.

Top module: `nic_regfile`

## Requirements
- R1: After reset the interrupt status reads 0x80, the command register reads 0x21 (page 0), `irq` and `tx_valid` are low, and every other register is 0x00.
- R2: Offset 0 reads back the last command value on every page. Command bits [7:6] select the page (0–3) that is used to decode offsets 1–15.
- R3: Page 0 writes go to these registers:
  - offset 1: ring start page (`ring_start`);
  - offset 2: ring stop page (`ring_stop`);
  - offset 3: boundary (also readable);
  - offset 4: transmit page;
  - offsets 5 and 6: transmit count low and high;
  - offsets 8 and 9: remote address low and high (also readable);
  - offsets 10 and 11: remote count low and high (`rdma_count`);
  - offset 14: data configuration (`data_cfg`);
  - offset 15: interrupt mask.
- R4: Page 1 offsets 1–6 are the station address bytes, offset 7 is the current page and offsets 8–15 are the multicast bytes. All of them read back what was written, and none of them alias a page 0 register.
- R5: Reads of an offset with no readable register return 0x00. On page 0 these are offsets 1, 2, 5, 6 and 10–15; on pages 2 and 3 they are offsets 1–15. Writes to pages 2 and 3 change nothing.
- R6: A write to the low or high byte of the remote address or the remote count leaves the other byte unchanged.
- R7: A write to interrupt status (page 0, offset 7) clears each bit in [6:0] that is 1 in the written value. Bit 7 is never cleared by this write.
- R8: `irq` is high exactly when (status AND mask) is nonzero. It is updated on the cycle after a write to either register.
- R9: A command write with the start bit (0x02) set clears status bit 7.
- R10: A command write with start set and remote read (0x08) or remote write (0x10) set, while the remote count is zero, sets status bit 6 (DMA complete). If the count is nonzero, or start is clear, bit 6 is not set.
- R11: A command write with start and transmit (0x04) set raises `tx_valid`, carrying the transmit page and the 16-bit count. The request holds until `tx_ready`, and no new request is accepted while one is outstanding.
- R12: A `tx_done` pulse makes transmit status (page 0, offset 4) read 0x01 and sets status bit 1.
- R13: Bit i of `evt_pulse` sets status bit i (bits 0–6). A set in the same cycle as a clear write to that bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 4 | Register offset within the page |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| evt_pulse | input | 7 | Engine event pulses that set status bits 6:0 |
| tx_done | input | 1 | Transmit completion pulse |
| tx_valid | output | 1 | Transmit request valid |
| tx_ready | input | 1 | Transmit request accepted |
| tx_page | output | 8 | Start page of the frame to send |
| tx_count | output | 16 | Byte count of the frame to send |
| ring_start | output | 8 | Receive ring first page |
| ring_stop | output | 8 | Receive ring end page |
| rdma_count | output | 16 | Remote DMA byte count |
| data_cfg | output | 8 | Data configuration byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a status register with bit 7 still set while the low bits are being set and cleared. Bit 7 returns only through reset, so the W1C sweep and the masked-interrupt checks on bit 7 are run first, before any start command. The zero-count DMA completion depends on the remote count register. The stimulus therefore tries every start/remote combination while the count is still at its reset value of zero, and only afterwards loads a nonzero low byte. The set-versus-clear race is produced by driving an event pulse in the same cycle as a status write.

// File: rtl/nic_regfile_pkg.sv
package nic_regfile_pkg;
  localparam int DW = 8;
  localparam int OW = 4;

  localparam logic [1:0] PG0 = 2'd0;
  localparam logic [1:0] PG1 = 2'd1;

  // command register bit positions
  localparam int B_STOP  = 0;
  localparam int B_START = 1;
  localparam int B_XMIT  = 2;
  localparam int B_RRD   = 3;
  localparam int B_RWR   = 4;

  // status bit positions
  localparam int S_TX  = 1;
  localparam int S_RDC = 6;
  localparam int S_RST = 7;

  // page 0 offsets
  localparam logic [OW-1:0] O_RSTART = 4'd1;
  localparam logic [OW-1:0] O_RSTOP  = 4'd2;
  localparam logic [OW-1:0] O_BNDRY  = 4'd3;
  localparam logic [OW-1:0] O_XPAGE  = 4'd4;
  localparam logic [OW-1:0] O_XCNTL  = 4'd5;
  localparam logic [OW-1:0] O_XCNTH  = 4'd6;
  localparam logic [OW-1:0] O_STAT   = 4'd7;
  localparam logic [OW-1:0] O_RADRL  = 4'd8;
  localparam logic [OW-1:0] O_RADRH  = 4'd9;
  localparam logic [OW-1:0] O_RCNTL  = 4'd10;
  localparam logic [OW-1:0] O_RCNTH  = 4'd11;
  localparam logic [OW-1:0] O_DCFG   = 4'd14;
  localparam logic [OW-1:0] O_MASK   = 4'd15;

  localparam logic [DW-1:0] CMD_RST_VAL  = 8'h21;
  localparam logic [DW-1:0] STAT_RST_VAL = 8'h80;
  localparam logic [DW-1:0] TSTAT_OK     = 8'h01;
endpackage

// File: rtl/nic_cfg_bank.sv
module nic_cfg_bank
  import nic_regfile_pkg::*;
#(
  parameter int STA_N = 6,
  parameter int MC_N  = 8,
  localparam int CW = 2 * DW,
  localparam int CUR_OFF = STA_N + 1,
  localparam int MC_BASE = STA_N + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    page,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ring_start,
  output logic [DW-1:0] ring_stop,
  output logic [DW-1:0] xmit_page,
  output logic [CW-1:0] xmit_cnt,
  output logic [CW-1:0] rdma_cnt,
  output logic [DW-1:0] data_cfg,
  output logic [DW-1:0] mask
);
  logic [DW-1:0] bndry_q, curpg_q;
  logic [CW-1:0] radr_q;
  logic [DW-1:0] sta_q [STA_N];
  logic [DW-1:0] mc_q  [MC_N];

  wire wr0 = wr_en && (page == PG0);
  wire wr1 = wr_en && (page == PG1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_start <= '0;
      ring_stop  <= '0;
      bndry_q    <= '0;
      xmit_page  <= '0;
      xmit_cnt   <= '0;
      radr_q     <= '0;
      rdma_cnt   <= '0;
      data_cfg   <= '0;
      mask       <= '0;
      curpg_q    <= '0;
    end else begin
      if (wr0) begin
        case (off)
          O_RSTART: ring_start <= wdata;
          O_RSTOP:  ring_stop  <= wdata;
          O_BNDRY:  bndry_q    <= wdata;
          O_XPAGE:  xmit_page  <= wdata;
          O_XCNTL:  xmit_cnt[DW-1:0]  <= wdata;
          O_XCNTH:  xmit_cnt[CW-1:DW] <= wdata;
          O_RADRL:  radr_q[DW-1:0]    <= wdata;
          O_RADRH:  radr_q[CW-1:DW]   <= wdata;
          O_RCNTL:  rdma_cnt[DW-1:0]  <= wdata;
          O_RCNTH:  rdma_cnt[CW-1:DW] <= wdata;
          O_DCFG:   data_cfg   <= wdata;
          O_MASK:   mask       <= wdata;
          default: ;
        endcase
      end
      if (wr1 && off == OW'(CUR_OFF)) curpg_q <= wdata;
    end
  end

  for (genvar g = 0; g < STA_N; g++) begin : g_sta
    always_ff @(posedge clk) begin
      if (!rst_n) sta_q[g] <= '0;
      else if (wr1 && off == OW'(g + 1)) sta_q[g] <= wdata;
    end
  end

  for (genvar g = 0; g < MC_N; g++) begin : g_mc
    always_ff @(posedge clk) begin
      if (!rst_n) mc_q[g] <= '0;
      else if (wr1 && off == OW'(MC_BASE + g)) mc_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (page == PG0) begin
      case (off)
        O_BNDRY: rdata = bndry_q;
        O_RADRL: rdata = radr_q[DW-1:0];
        O_RADRH: rdata = radr_q[CW-1:DW];
        default: rdata = '0;
      endcase
    end else if (page == PG1) begin
      for (int i = 0; i < STA_N; i++)
        if (off == OW'(i + 1)) rdata = sta_q[i];
      if (off == OW'(CUR_OFF)) rdata = curpg_q;
      for (int i = 0; i < MC_N; i++)
        if (off == OW'(MC_BASE + i)) rdata = mc_q[i];
    end
  end

  AST_HALF_KEEP_ADR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && off == O_RADRL) |=> radr_q[CW-1:DW] == $past(radr_q[CW-1:DW])); // R6
  AST_HALF_KEEP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && off == O_RCNTH) |=> rdma_cnt[DW-1:0] == $past(rdma_cnt[DW-1:0])); // R6
  AST_HIGH_PAGE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && page[1]) |=> $stable(bndry_q) && $stable(mask) && $stable(curpg_q)); // R5
endmodule

// File: rtl/nic_cmd_ctl.sv
module nic_cmd_ctl
  import nic_regfile_pkg::*;
#(
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] rdma_cnt,
  input  logic [DW-1:0] xmit_page_cfg,
  input  logic [CW-1:0] xmit_cnt_cfg,
  input  logic          tx_ready,
  input  logic          tx_done,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] tstat_q,
  output logic          start_hit,
  output logic          dma_zero_hit,
  output logic          tx_valid,
  output logic [DW-1:0] tx_page,
  output logic [CW-1:0] tx_count
);
  logic xmit_hit;

  assign start_hit    = cmd_wr && wdata[B_START];
  assign dma_zero_hit = start_hit && (wdata[B_RRD] || wdata[B_RWR]) && (rdma_cnt == '0);
  assign xmit_hit     = start_hit && wdata[B_XMIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_RST_VAL;
      tstat_q  <= '0;
      tx_valid <= 1'b0;
      tx_page  <= '0;
      tx_count <= '0;
    end else begin
      if (cmd_wr)  cmd_q   <= wdata;
      if (tx_done) tstat_q <= TSTAT_OK;
      if (tx_valid && tx_ready) begin
        tx_valid <= 1'b0;
      end else if (xmit_hit && !tx_valid) begin
        tx_valid <= 1'b1;
        tx_page  <= xmit_page_cfg;
        tx_count <= xmit_cnt_cfg;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_page) && $stable(tx_count)); // R11
  AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_hit && !tx_valid) |=> tx_valid && tx_count == $past(xmit_cnt_cfg)); // R11
  AST_TSTAT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> tstat_q == TSTAT_OK); // R12
endmodule

// File: rtl/nic_int_ctl.sv
module nic_int_ctl
  import nic_regfile_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mask,
  input  logic          start_hit,
  input  logic          dma_zero_hit,
  input  logic          tx_done,
  input  logic [DW-2:0] evt_pulse,
  output logic [DW-1:0] stat_q,
  output logic          irq
);
  logic [DW-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_wr) stat_d[DW-2:0] = stat_d[DW-2:0] & ~wdata[DW-2:0];
    if (start_hit) stat_d[S_RST] = 1'b0;
    stat_d[DW-2:0] = stat_d[DW-2:0] | evt_pulse;
    if (tx_done) stat_d[S_TX] = 1'b1;
    if (dma_zero_hit) stat_d[S_RDC] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= STAT_RST_VAL;
    else        stat_q <= stat_d;
  end

  assign irq = |(stat_q & mask);

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[S_RST] && !start_hit) |=> stat_q[S_RST]); // R7
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> !stat_q[S_RST]); // R9
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && evt_pulse == '0 && !tx_done && !dma_zero_hit)
      |=> (stat_q[DW-2:0] & $past(wdata[DW-2:0])) == '0); // R7
  AST_DMA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dma_zero_hit |=> stat_q[S_RDC]); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> (stat_q[DW-2:0] & $past(evt_pulse)) == $past(evt_pulse)); // R13
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R8
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_regfile_pkg::*;
#(
  parameter int STA_N = 6,
  parameter int MC_N  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [6:0]    evt_pulse,
  input  logic          tx_done,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_page,
  output logic [15:0]   tx_count,
  output logic [7:0]    ring_start,
  output logic [7:0]    ring_stop,
  output logic [15:0]   rdma_count,
  output logic [7:0]    data_cfg,
  output logic          irq
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] cmd_q, tstat_q, stat_q, mask, bank_rdata, xmit_page;
  logic [CW-1:0] xmit_cnt;
  logic [1:0]    page;
  logic          cmd_wr, reg_wr, stat_wr, start_hit, dma_zero_hit;

  assign page    = cmd_q[DW-1:DW-2];
  assign cmd_wr  = wr_en && (addr == '0);
  assign reg_wr  = wr_en && (addr != '0);
  assign stat_wr = reg_wr && (page == PG0) && (addr == O_STAT);

  nic_cfg_bank #(.STA_N(STA_N), .MC_N(MC_N)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .page(page), .off(addr),
    .wdata(wdata), .rdata(bank_rdata), .ring_start(ring_start),
    .ring_stop(ring_stop), .xmit_page(xmit_page), .xmit_cnt(xmit_cnt),
    .rdma_cnt(rdma_count), .data_cfg(data_cfg), .mask(mask)
  );

  nic_cmd_ctl u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(wdata),
    .rdma_cnt(rdma_count), .xmit_page_cfg(xmit_page), .xmit_cnt_cfg(xmit_cnt),
    .tx_ready(tx_ready), .tx_done(tx_done), .cmd_q(cmd_q), .tstat_q(tstat_q),
    .start_hit(start_hit), .dma_zero_hit(dma_zero_hit), .tx_valid(tx_valid),
    .tx_page(tx_page), .tx_count(tx_count)
  );

  nic_int_ctl u_int (
    .clk(clk), .rst_n(rst_n), .clr_wr(stat_wr), .wdata(wdata), .mask(mask),
    .start_hit(start_hit), .dma_zero_hit(dma_zero_hit), .tx_done(tx_done),
    .evt_pulse(evt_pulse), .stat_q(stat_q), .irq(irq)
  );

  always_comb begin
    if (addr == '0)                          rdata = cmd_q;
    else if (page == PG0 && addr == O_XPAGE) rdata = tstat_q;
    else if (page == PG0 && addr == O_STAT)  rdata = stat_q;
    else                                     rdata = bank_rdata;
  end

  AST_CMD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> page == $past(wdata[DW-1:DW-2])); // R2
  AST_NO_DMA_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !wdata[B_START] && !stat_q[S_RDC] && evt_pulse == '0) |=> !stat_q[S_RDC]); // R10
endmodule

// File: tb/test_nic_regfile.sv
`timescale 1ns/1ps
module test_nic_regfile;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tx_done = 1'b0, tx_ready = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [6:0] evt_pulse = '0;
  logic [7:0] rdata, tx_page, ring_start, ring_stop, data_cfg;
  logic [15:0] tx_count, rdma_count;
  logic tx_valid, irq;
  int n_vec = 0, n_bad = 0;
  logic [7:0] rv, exp_s;

  always #10 clk = ~clk;

  nic_regfile i_nic_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_pulse(evt_pulse), .tx_done(tx_done), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_page(tx_page), .tx_count(tx_count),
    .ring_start(ring_start), .ring_stop(ring_stop), .rdma_count(rdma_count),
    .data_cfg(data_cfg), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); evt_pulse = v;
    @(negedge clk); evt_pulse = '0;
  endtask

  function automatic logic [7:0] p1val(input int off);
    return 8'((off * 8'h11) ^ 8'h5A);
  endfunction

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd7, rv); chk("R1 status", rv, 8'h80);
    rd(4'd0, rv); chk("R1 cmd", rv, 8'h21);
    chk("R1 irq", irq, 0); chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rdma_count", rdma_count, 0); chk("R1 ring_start", ring_start, 0);
    rd(4'd4, rv); chk("R1 tstat", rv, 8'h00);
    // R13 set every low bit, R7 clear each bit in turn, bit 7 stays
    pulse(7'h7F);
    rd(4'd7, rv); chk("R13 all set", rv, 8'hFF);
    exp_s = 8'hFF;
    for (int i = 0; i < 7; i++) begin
      wr(4'd7, 8'(1 << i));
      exp_s = exp_s & ~8'(1 << i);
      rd(4'd7, rv); chk("R7 w1c bit", rv, exp_s);
    end
    wr(4'd7, 8'hFF); rd(4'd7, rv); chk("R7 bit7 kept", rv, 8'h80);
    // R8 bit 7 through mask
    wr(4'd15, 8'h80); chk("R8 irq bit7", irq, 1);
    wr(4'd15, 8'h7F); chk("R8 irq masked", irq, 0);
    // R9 start clears reset flag
    wr(4'd0, 8'h22); rd(4'd7, rv); chk("R9 start clears", rv, 8'h00);
    // R8 sweep status bit x mask bit
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      for (int k = 0; k < 8; k++) begin
        wr(4'd15, 8'(1 << k));
        chk("R8 irq sweep", irq, (i == k) ? 1 : 0);
      end
      wr(4'd7, 8'h7F);
      chk("R8 irq after clear", irq, 0);
    end
    wr(4'd15, 8'h00);
    // R10 zero-count DMA completion
    wr(4'd0, 8'h0A); rd(4'd7, rv); chk("R10 rread zero", rv, 8'h40);
    wr(4'd7, 8'h40);
    wr(4'd0, 8'h12); rd(4'd7, rv); chk("R10 rwrite zero", rv, 8'h40);
    wr(4'd7, 8'h40);
    wr(4'd0, 8'h08); rd(4'd7, rv); chk("R10 no start", rv, 8'h00);
    wr(4'd10, 8'h05); chk("R3 rcnt lo", rdma_count, 16'h0005);
    wr(4'd0, 8'h0A); rd(4'd7, rv); chk("R10 nonzero count", rv, 8'h00);
    // R6 halves
    wr(4'd11, 8'h02); chk("R6 rcnt hi", rdma_count, 16'h0205);
    wr(4'd10, 8'h00); chk("R6 rcnt lo keeps hi", rdma_count, 16'h0200);
    wr(4'd8, 8'h34); wr(4'd9, 8'h12);
    wr(4'd8, 8'h99);
    rd(4'd9, rv); chk("R6 radr hi kept", rv, 8'h12);
    rd(4'd8, rv); chk("R6 radr lo", rv, 8'h99);
    // R3 page 0 map
    wr(4'd1, 8'h40); wr(4'd2, 8'h80); wr(4'd14, 8'h49);
    chk("R3 ring_start", ring_start, 8'h40);
    chk("R3 ring_stop", ring_stop, 8'h80);
    chk("R3 data_cfg", data_cfg, 8'h49);
    wr(4'd3, 8'h47); rd(4'd3, rv); chk("R3 boundary", rv, 8'h47);
    // R11 transmit request
    wr(4'd4, 8'h4C); wr(4'd5, 8'hEA); wr(4'd6, 8'h05);
    wr(4'd0, 8'h26);
    chk("R11 tx_valid", tx_valid, 1);
    chk("R11 tx_page", tx_page, 8'h4C);
    chk("R11 tx_count", tx_count, 16'h05EA);
    wr(4'd5, 8'h11);
    wr(4'd0, 8'h26);
    repeat (3) @(negedge clk);
    chk("R11 held", tx_valid, 1);
    chk("R11 count stable", tx_count, 16'h05EA);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R11 accepted", tx_valid, 0);
    // R12 completion
    rd(4'd4, rv); chk("R12 tstat before", rv, 8'h00);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    rd(4'd4, rv); chk("R12 tstat", rv, 8'h01);
    rd(4'd7, rv); chk("R12 status tx", rv, 8'h02);
    // R13 set wins over clear in same cycle
    @(negedge clk); addr = 4'd7; wdata = 8'h03; wr_en = 1'b1; evt_pulse = 7'h01;
    @(negedge clk); wr_en = 1'b0; evt_pulse = '0;
    rd(4'd7, rv); chk("R13 set wins", rv, 8'h01);
    wr(4'd7, 8'h7F);
    // R5 page 0 unreadable offsets
    for (int off = 1; off < 16; off++) begin
      if (off != 3 && off != 4 && off != 7 && off != 8 && off != 9) begin
        rd(4'(off), rv); chk("R5 page0 unmapped", rv, 8'h00);
      end
    end
    // R2 page select readback
    for (int p = 0; p < 4; p++) begin
      wr(4'd0, {2'(p), 6'h21}); rd(4'd0, rv); chk("R2 cmd readback", rv, {2'(p), 6'h21});
    end
    // R4 page 1 map
    wr(4'd0, 8'h61);
    for (int off = 1; off < 16; off++) wr(4'(off), p1val(off));
    for (int off = 1; off < 16; off++) begin
      rd(4'(off), rv); chk("R4 page1 readback", rv, p1val(off));
    end
    chk("R4 no alias ring_start", ring_start, 8'h40);
    // R5 pages 2/3 inert
    for (int p = 2; p < 4; p++) begin
      wr(4'd0, {2'(p), 6'h21});
      for (int off = 1; off < 16; off++) wr(4'(off), 8'hFF);
      for (int off = 1; off < 16; off++) begin
        rd(4'(off), rv); chk("R5 high page read", rv, 8'h00);
      end
    end
    chk("R5 ring_stop kept", ring_stop, 8'h80);
    chk("R5 irq", irq, 0);
    wr(4'd0, 8'h61);
    for (int off = 1; off < 16; off++) begin
      rd(4'(off), rv); chk("R5 page1 kept", rv, p1val(off));
    end
    wr(4'd0, 8'h21);
    rd(4'd3, rv); chk("R4 boundary kept", rv, 8'h47);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule